// File: doc/BRIEF.md
# Memory Command Sequence Executor

This block runs short programs of 32-bit microcode words that drive a DDR3 command bus and the strobes of the data path beside it. A host fills an on-block command store through a simple write port. It then pulses `start` with the address of the first word. The executor fetches and decodes the words one after another until it reaches a skip word whose done bit is set. At that point it drops `busy_o` and pulses `done_o`.

Each word is either a memory command or a skip word. Bit 31 tells the two kinds apart. A command word places a command code, a bank and a row or column address on the pins for one slot. If its idle flag is set, a second slot follows in which no command is issued. A skip word issues no command. It holds its control pattern on the pins for a programmable number of slots. This keeps strobes such as DQS toggling, termination and buffer write or read alive across idle time.

Each slot lasts one executor clock. Each executor clock spans two memory clocks, so a pause count of 256 covers the 512-clock wait after a long ZQ calibration. Page sequences put 64 column commands in a row, with the column address advancing by 8 each time. The buffer page reset strobe normally travels with the closing precharge.

Top module: `mseq_engine`

## Requirements
- R1: A word with bit 31 = 1 is a command word with these fields: [30] idle flag, [29:27] command code, [26:24] bank, [23:9] address, [8:0] controls. The command codes are 1 ZQ calibration, 2 read, 3 write, 4 activate, 5 precharge, 6 refresh and 7 mode-register set. In the word's issue slot, `cmd_code_o`, `bank_o` and `addr_o` carry the code, the bank and the address.
- R2: A word with bit 31 = 0 is a skip word with these fields: [30] done, [26:24] bank, [19:10] pause count N, [9:0] controls. When done is clear, the skip word occupies N+1 consecutive slots. In each of these slots the command code is 0, the address is 0, the bank is the word's bank and the controls are the word's controls.
- R3: A command word with the idle flag set is followed by one extra slot. In that slot the command code is 0, the address is 0, and the bank and controls are the same as in the issue slot. With the idle flag clear, the next word follows in the very next slot.
- R4: A skip word with done set occupies exactly one slot and ignores its pause count. In that slot its controls are driven, `done_o` is 1 for that single cycle and `busy_o` is already 0.
- R5: `cmd_code_o` is 0 (no operation) in every cycle that is not a command word's issue slot. While the executor is idle, `bank_o`, `addr_o` and every control except `cke_o` are 0.
- R6: `cke_o` is control bit 9. Only skip words change it. It keeps its value through command words and while idle, and it is 0 after reset.
- R7: `start` is accepted only while `busy_o` is 0. It latches `start_addr`, and `busy_o` is 1 from the next cycle. A `start` pulse while busy has no effect on the running program.
- R8: The first slot of a program appears on the outputs two cycles after the cycle in which `start` is accepted. Words then follow slot by slot with no gaps, so a skip with N = 0 or a command without the idle flag takes exactly one cycle.
- R9: Control bit positions are: 0 ODT, 1 bank-select, 2 DQ enable, 3 DQS enable, 4 DQS toggle, 5 termination enable, 6 buffer write, 7 buffer read, 8 buffer page reset. The pause count reaches at least 256, and a count of 256 yields 257 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Executor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write enable of the command store |
| ld_addr | input | PC_W | Command store write address |
| ld_data | input | 32 | Command word to store |
| start | input | 1 | Launch request |
| start_addr | input | PC_W | Address of the first word |
| busy_o | output | 1 | Program running |
| done_o | output | 1 | One-cycle completion pulse |
| cmd_code_o | output | 3 | Command code, 0 = no operation |
| bank_o | output | 3 | Bank address |
| addr_o | output | 15 | Row or column address |
| odt_o | output | 1 | On-die termination request |
| cke_o | output | 1 | Clock enable |
| bsel_o | output | 1 | Bank-select sideband |
| dq_en_o | output | 1 | DQ output enable |
| dqs_en_o | output | 1 | DQS output enable |
| dqs_tgl_o | output | 1 | DQS toggle |
| term_en_o | output | 1 | Receiver termination enable |
| buf_wr_o | output | 1 | Data buffer write strobe |
| buf_rd_o | output | 1 | Data buffer read strobe |
| page_rst_o | output | 1 | Data buffer page reset |

## Verification
The hardest case to reach is a launch request that arrives while a long pause is running. If it leaked through, it would reload the program counter in the middle of a word and corrupt the remaining slots. The bench runs a 257-slot skip word and fires `start` with a different address about twenty slots into it. The scoreboard must still see every remaining slot of the original program, followed by its done slot. A second stress case is a 64-command page with the column stepping by 8, which shows that prefetch and idle-slot insertion keep pace with no gaps.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int WORD_W  = 32;
  localparam int CTL_W   = 10;
  localparam int PAUSE_W = 10;
  localparam int ADDR_W  = 15;
  localparam int BANK_W  = 3;
  localparam int CODE_W  = 3;
  localparam int CKE_BIT = 9;

  typedef enum logic [CODE_W-1:0] {
    OP_NONE = 3'd0, OP_ZQ = 3'd1, OP_RD = 3'd2, OP_WR = 3'd3,
    OP_ACT = 3'd4, OP_PRE = 3'd5, OP_REF = 3'd6, OP_MRS = 3'd7
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_PRIME, ST_RUN} run_state_e;

  function automatic logic is_cmd(input logic [WORD_W-1:0] w);
    return w[31];
  endfunction

  // bit 30 is the idle flag in command words and the done flag in skip words
  function automatic logic flag30(input logic [WORD_W-1:0] w);
    return w[30];
  endfunction

  function automatic logic [CODE_W-1:0] op_of(input logic [WORD_W-1:0] w);
    return w[29:27];
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(input logic [WORD_W-1:0] w);
    return w[26:24];
  endfunction

  function automatic logic [ADDR_W-1:0] addr_of(input logic [WORD_W-1:0] w);
    return w[23:9];
  endfunction

  function automatic logic [PAUSE_W-1:0] pause_of(input logic [WORD_W-1:0] w);
    return w[19:10];
  endfunction

  // slots a word needs beyond its first one
  function automatic logic [PAUSE_W-1:0] extra_slots(input logic [WORD_W-1:0] w);
    if (is_cmd(w))
      return {{(PAUSE_W-1){1'b0}}, flag30(w)};
    else if (flag30(w))
      return '0;
    else
      return pause_of(w);
  endfunction
endpackage

// File: rtl/mseq_cmd_mem.sv
module mseq_cmd_mem #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/mseq_fetch_ctrl.sv
module mseq_fetch_ctrl
  import mseq_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic [WORD_W-1:0] word,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic              running,
  output logic              first,
  output logic              fin,
  output logic              hold,
  output logic              busy
);
  run_state_e           state;
  logic [AW-1:0]        pc;
  logic [PAUSE_W-1:0]   remain;
  logic [PAUSE_W-1:0]   need;
  logic                 adv;

  always_comb begin
    need    = extra_slots(word);
    running = (state == ST_RUN);
    fin     = running && first && !is_cmd(word) && flag30(word);
    hold    = running && !first;
    adv     = running && !fin && (first ? (need == '0) : (remain == '0));
    rd_en   = (state == ST_PRIME) || adv;
    rd_addr = pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pc     <= '0;
      remain <= '0;
      first  <= 1'b0;
      busy   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          pc    <= start_addr;
          state <= ST_PRIME;
          busy  <= 1'b1;
        end
        ST_PRIME: begin
          pc    <= pc + 1'b1;
          first <= 1'b1;
          state <= ST_RUN;
        end
        ST_RUN: begin
          if (fin) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end else if (adv) begin
            pc    <= pc + 1'b1;
            first <= 1'b1;
          end else if (first) begin
            remain <= need - 1'b1;
            first  <= 1'b0;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mseq_out_stage.sv
module mseq_out_stage
  import mseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic              first,
  input  logic              fin,
  input  logic [WORD_W-1:0] word,
  output logic [CODE_W-1:0] code_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CTL_W-1:0]  ctl_q,
  output logic              done_q
);
  logic issue;
  assign issue = running && first && is_cmd(word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      bank_q <= '0;
      addr_q <= '0;
      ctl_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (running) begin
        code_q <= issue ? op_of(word) : OP_NONE;
        addr_q <= issue ? addr_of(word) : '0;
        bank_q <= bank_of(word);
        ctl_q[CKE_BIT-1:0] <= word[CKE_BIT-1:0];
        if (!is_cmd(word)) ctl_q[CKE_BIT] <= word[CKE_BIT];
      end else begin
        code_q <= OP_NONE;
        addr_q <= '0;
        bank_q <= '0;
        ctl_q[CKE_BIT-1:0] <= '0;
      end
    end
  end
endmodule

// File: rtl/mseq_engine.sv
module mseq_engine
  import mseq_pkg::*;
#(
  parameter int MEM_DEPTH = 1024,
  localparam int PC_W = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [PC_W-1:0]   ld_addr,
  input  logic [31:0]       ld_data,
  input  logic              start,
  input  logic [PC_W-1:0]   start_addr,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        cmd_code_o,
  output logic [2:0]        bank_o,
  output logic [14:0]       addr_o,
  output logic              odt_o,
  output logic              cke_o,
  output logic              bsel_o,
  output logic              dq_en_o,
  output logic              dqs_en_o,
  output logic              dqs_tgl_o,
  output logic              term_en_o,
  output logic              buf_wr_o,
  output logic              buf_rd_o,
  output logic              page_rst_o
);
  logic [WORD_W-1:0] cur_word;
  logic [PC_W-1:0]   rd_addr;
  logic              rd_en, running_w, first_w, fin_w, hold_w;
  logic [CTL_W-1:0]  ctl_bus;

  mseq_cmd_mem #(.DEPTH(MEM_DEPTH), .AW(PC_W), .DW(WORD_W)) u_mem (
    .clk(clk), .we(ld_en), .waddr(ld_addr), .wdata(ld_data),
    .re(rd_en), .raddr(rd_addr), .rdata(cur_word)
  );

  mseq_fetch_ctrl #(.AW(PC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word(cur_word), .rd_en(rd_en), .rd_addr(rd_addr), .running(running_w),
    .first(first_w), .fin(fin_w), .hold(hold_w), .busy(busy_o)
  );

  mseq_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .running(running_w), .first(first_w), .fin(fin_w),
    .word(cur_word), .code_q(cmd_code_o), .bank_q(bank_o), .addr_q(addr_o),
    .ctl_q(ctl_bus), .done_q(done_o)
  );

  assign odt_o      = ctl_bus[0];
  assign bsel_o     = ctl_bus[1];
  assign dq_en_o    = ctl_bus[2];
  assign dqs_en_o   = ctl_bus[3];
  assign dqs_tgl_o  = ctl_bus[4];
  assign term_en_o  = ctl_bus[5];
  assign buf_wr_o   = ctl_bus[6];
  assign buf_rd_o   = ctl_bus[7];
  assign page_rst_o = ctl_bus[8];
  assign cke_o      = ctl_bus[CKE_BIT];
endmodule

// File: rtl/mseq_engine_chk.sv
module mseq_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] cmd_code_o,
  input logic [9:0] ctl_bus,
  input logic       hold_w,
  input logic       fin_w
);
  p_idle_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> (cmd_code_o == 3'd0));

  p_cmd_needs_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code_o != 3'd0) |-> busy_o);

  p_hold_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_w |=> ($stable(ctl_bus) && cmd_code_o == 3'd0));

  p_done_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_busy_fall_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fin_w) |=> busy_o);
endmodule

bind mseq_engine mseq_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .cmd_code_o(cmd_code_o), .ctl_bus(ctl_bus), .hold_w(hold_w), .fin_w(fin_w)
);

// File: tb/tb_mseq_engine.sv
module tb_mseq_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [9:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic start = 1'b0;
  logic [9:0] start_addr = '0;
  logic busy_o, done_o, odt_o, cke_o, bsel_o, dq_en_o, dqs_en_o, dqs_tgl_o;
  logic term_en_o, buf_wr_o, buf_rd_o, page_rst_o;
  logic [2:0] cmd_code_o, bank_o;
  logic [14:0] addr_o;

  always #4 clk = ~clk;

  mseq_engine dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .start(start), .start_addr(start_addr), .busy_o(busy_o), .done_o(done_o),
    .cmd_code_o(cmd_code_o), .bank_o(bank_o), .addr_o(addr_o), .odt_o(odt_o),
    .cke_o(cke_o), .bsel_o(bsel_o), .dq_en_o(dq_en_o), .dqs_en_o(dqs_en_o),
    .dqs_tgl_o(dqs_tgl_o), .term_en_o(term_en_o), .buf_wr_o(buf_wr_o),
    .buf_rd_o(buf_rd_o), .page_rst_o(page_rst_o)
  );

  typedef struct {
    logic [32:0] v;
    string       req;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] prog[$];
  int          n_checks = 0;
  int          n_errors = 0;
  logic        mon_on = 1'b0;
  logic        model_cke = 1'b0;

  task automatic check(input logic ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // packing: busy, done, code, bank, addr, ctl[9:0]
  function automatic logic [32:0] observe();
    return {busy_o, done_o, cmd_code_o, bank_o, addr_o,
            cke_o, page_rst_o, buf_rd_o, buf_wr_o, term_en_o,
            dqs_tgl_o, dqs_en_o, dq_en_o, bsel_o, odt_o};
  endfunction

  function automatic logic [31:0] mk_cmd(input logic [2:0] code, input logic [2:0] bank,
                                         input logic [14:0] a, input logic idle, input logic [8:0] ctl);
    return {1'b1, idle, code, bank, a, ctl};
  endfunction

  function automatic logic [31:0] mk_skip(input logic done, input logic [2:0] bank,
                                          input logic [9:0] pause, input logic [9:0] ctl);
    return {1'b0, done, 3'b000, bank, 4'b0000, pause, ctl};
  endfunction

  // expected slot stream, written from the requirements
  task automatic predict(input string tag);
    foreach (prog[i]) begin
      logic [31:0] w;
      w = prog[i];
      if (w[31]) begin
        exp_q.push_back('{{1'b1, 1'b0, w[29:27], w[26:24], w[23:9], model_cke, w[8:0]}, tag});
        if (w[30])
          exp_q.push_back('{{1'b1, 1'b0, 3'd0, w[26:24], 15'd0, model_cke, w[8:0]}, "R3"});
      end else begin
        model_cke = w[9];
        if (w[30]) begin
          exp_q.push_back('{{1'b0, 1'b1, 3'd0, w[26:24], 15'd0, w[9:0]}, "R4"});
          break;
        end
        for (int k = 0; k <= int'(w[19:10]); k++)
          exp_q.push_back('{{1'b1, 1'b0, 3'd0, w[26:24], 15'd0, w[9:0]}, "R2"});
      end
    end
  endtask

  task automatic run_prog(input int base, input string tag, input bit inject);
    foreach (prog[i]) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 10'(base + i); ld_data = prog[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    predict(tag);
    start = 1'b1; start_addr = 10'(base);
    @(negedge clk);
    start = 1'b0;
    check(busy_o == 1'b1, "R7", {32'd0, busy_o}, 33'd1);
    @(posedge clk);
    @(posedge clk);
    mon_on = 1'b1;
    if (inject) begin
      repeat (20) @(negedge clk);
      start = 1'b1; start_addr = 10'd5;
      @(negedge clk);
      start = 1'b0;
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
    mon_on = 1'b0;
    check(observe() == {2'b00, 3'd0, 3'd0, 15'd0, model_cke, 9'd0}, "R5 R6 idle",
          observe(), {2'b00, 3'd0, 3'd0, 15'd0, model_cke, 9'd0});
    repeat (3) @(negedge clk);
    check(observe() == {2'b00, 3'd0, 3'd0, 15'd0, model_cke, 9'd0}, "R7 stays idle",
          observe(), {2'b00, 3'd0, 3'd0, 15'd0, model_cke, 9'd0});
    prog.delete();
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(observe() === e.v, e.req, observe(), e.v);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(observe() == 33'd0, "R5 reset", observe(), 33'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(observe() == 33'd0, "R6 reset cke", observe(), 33'd0);

    // R1 R3 R8: activate, short skip, two reads, precharge with page reset
    prog.push_back(mk_cmd(3'd4, 3'd2, 15'h1234, 1'b0, 9'h000));
    prog.push_back(mk_skip(1'b0, 3'd0, 10'd1, 10'h000));
    prog.push_back(mk_cmd(3'd2, 3'd2, 15'h0010, 1'b1, 9'h04E));
    prog.push_back(mk_cmd(3'd2, 3'd2, 15'h0018, 1'b0, 9'h04E));
    prog.push_back(mk_cmd(3'd5, 3'd2, 15'h1234, 1'b0, 9'h120));
    prog.push_back(mk_skip(1'b1, 3'd0, 10'd5, 10'h000));
    run_prog(0, "R1", 1'b0);

    // R6: clock enable set by a skip word, held across all command kinds
    prog.push_back(mk_skip(1'b0, 3'd1, 10'd0, 10'h200));
    prog.push_back(mk_cmd(3'd3, 3'd1, 15'h0040, 1'b1, 9'h01D));
    prog.push_back(mk_cmd(3'd6, 3'd0, 15'h0000, 1'b0, 9'h000));
    prog.push_back(mk_cmd(3'd7, 3'd3, 15'h0004, 1'b0, 9'h000));
    prog.push_back(mk_cmd(3'd1, 3'd0, 15'h0400, 1'b0, 9'h000));
    prog.push_back(mk_skip(1'b1, 3'd0, 10'd0, 10'h200));
    run_prog(100, "R6", 1'b0);

    // R9 R7: 256-count pause with strobes, start injected mid-pause
    prog.push_back(mk_skip(1'b0, 3'd6, 10'd256, 10'h078));
    prog.push_back(mk_skip(1'b0, 3'd0, 10'd2, 10'h020));
    prog.push_back(mk_skip(1'b1, 3'd0, 10'd0, 10'h000));
    run_prog(300, "R9", 1'b1);

    // R1 R8: 64-column page read, column step of 8, back to back
    for (int i = 0; i < 64; i++)
      prog.push_back(mk_cmd(3'd2, 3'd5, 15'(i * 8), 1'b1, 9'h084));
    prog.push_back(mk_cmd(3'd5, 3'd5, 15'h0077, 1'b0, 9'h100));
    prog.push_back(mk_skip(1'b1, 3'd0, 10'd9, 10'h000));
    run_prog(400, "R8", 1'b0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule